// File: doc/BRIEF.md
# ATR Timeout Monitor

This block watches the timing of a smart card's Answer-To-Reset with two down-counting timers that run in different units. The start timer is armed by a pulse that marks an edge of the card reset line. It counts card-clock ticks until the receiver reports the start bit of the first ATR character. The duration timer is armed by that same first-start-bit pulse and counts etu ticks until software drops the duration-enable bit, which it does once the whole ATR has arrived.

If either timer reaches zero before it is stopped, it raises its own sticky interrupt flag. The flag stays set until its clear input is pulsed. Each threshold is held in a 16-bit register with a write strobe. A write to a running timer reloads the live count at once, and the timer then counts down from the new value. A write to an idle timer only updates the stored threshold.

Top module: `atr_timeout_monitor`

## Requirements
- R1: After reset both flags are 0, the start threshold is 40000 and the duration threshold is 19200.
- R2: A pulse on rst_edge_i loads the start threshold N into the start timer. start_irq_o becomes 1 on the clock edge that samples the max(N,1)-th cycle with cclk_tick_i high after arming. Cycles with cclk_tick_i low are not counted.
- R3: A pulse on first_start_i stops a running start timer, and no start flag is raised afterwards.
- R4: With dur_en_i at 1, a pulse on first_start_i loads the duration threshold N into the duration timer. dur_irq_o becomes 1 on the max(N,1)-th cycle with etu_tick_i high after arming. Card-clock ticks do not advance this timer.
- R5: Whenever dur_en_i is 0, the duration timer is disarmed and cannot raise dur_irq_o. Setting dur_en_i to 1 again does not resume the count; the timer waits for a new first_start_i.
- R6: A threshold write while its timer is running loads the written value V into the count. Any tick in the write cycle is ignored, and the flag rises on the max(V,1)-th tick after the write.
- R7: A threshold write while its timer is idle changes no flag and starts no count. The stored value is used at the next arming.
- R8: Each timer fires once. After firing it stays idle and raises no further flag until its arming event occurs again.
- R9: Each flag stays at 1 until its clear input is pulsed. If an expiry and a clear fall in the same cycle, the flag ends up at 1.
- R10: A rst_edge_i pulse restarts a running start timer from its threshold and disarms the duration timer. When rst_edge_i and first_start_i fall in the same cycle, rst_edge_i wins: the start timer is armed and the duration timer is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cclk_tick_i | input | 1 | One-cycle card-clock tick |
| etu_tick_i | input | 1 | One-cycle etu tick |
| rst_edge_i | input | 1 | Pulse on an edge of the card reset line |
| first_start_i | input | 1 | Pulse on the start bit of the first ATR character |
| dur_en_i | input | 1 | Duration-timer enable |
| start_thr_i | input | 16 | Start threshold write data |
| start_thr_we_i | input | 1 | Start threshold write strobe |
| dur_thr_i | input | 16 | Duration threshold write data |
| dur_thr_we_i | input | 1 | Duration threshold write strobe |
| start_clr_i | input | 1 | Clears the start-timeout flag |
| dur_clr_i | input | 1 | Clears the duration-timeout flag |
| start_irq_o | output | 1 | Start-timeout flag |
| dur_irq_o | output | 1 | Duration-timeout flag |

## Verification
Two pairs of functions can land in the same cycle.

- **Expiry and clear.** The final counting tick is driven together with the clear pulse. The flag is judged to stay at 1, and only a later clear on its own drops it.
- **Threshold write and tick.** A threshold write is driven in the same cycle as a tick on a running timer. The flag must then rise exactly on the new value's count of further ticks, which shows that the tick in the write cycle was dropped.

The bench also drives rst_edge_i and first_start_i together and judges which timer ends up armed.

// File: rtl/atr_mon_pkg.sv
package atr_mon_pkg;
  localparam int unsigned NUM_TMR = 2;
  typedef enum int unsigned {
    TMR_START = 0,
    TMR_DUR   = 1
  } tmr_idx_e;
endpackage

// File: rtl/atr_down_timer.sv
module atr_down_timer #(
  parameter int unsigned     CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_THR = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             thr_we_i,
  output logic             run_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] thr_q, cnt_q, thr_load;
  logic             run_q, last;

  assign thr_load = thr_we_i ? thr_i : thr_q;
  assign last     = (cnt_q <= CNT_W'(1));
  // arm > stop > reload > tick
  assign fire_o   = run_q & ~arm_i & ~stop_i & ~thr_we_i & tick_i & last;
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= RST_THR;
    end else if (thr_we_i) begin
      thr_q <= thr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm_i) begin
      run_q <= 1'b1;
      cnt_q <= thr_load;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (thr_we_i) begin
        cnt_q <= thr_i;
      end else if (tick_i) begin
        if (last) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/atr_irq_flag.sv
module atr_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/atr_timeout_monitor.sv
module atr_timeout_monitor #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned START_RST = 40000,
  parameter int unsigned DUR_RST   = 19200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cclk_tick_i,
  input  logic             etu_tick_i,
  input  logic             rst_edge_i,
  input  logic             first_start_i,
  input  logic             dur_en_i,
  input  logic [CNT_W-1:0] start_thr_i,
  input  logic             start_thr_we_i,
  input  logic [CNT_W-1:0] dur_thr_i,
  input  logic             dur_thr_we_i,
  input  logic             start_clr_i,
  input  logic             dur_clr_i,
  output logic             start_irq_o,
  output logic             dur_irq_o
);
  import atr_mon_pkg::*;

  logic [NUM_TMR-1:0] arm, stop, tick, we, fire, run, clr, irq;
  logic [CNT_W-1:0]   thr [NUM_TMR];

  // start timer: reset-line edge arms, first start bit aborts silently
  assign arm[TMR_START]  = rst_edge_i;
  assign stop[TMR_START] = first_start_i;
  assign tick[TMR_START] = cclk_tick_i;
  assign thr[TMR_START]  = start_thr_i;
  assign we[TMR_START]   = start_thr_we_i;
  assign clr[TMR_START]  = start_clr_i;

  // duration timer: armed by first start bit, disarmed by enable low or new reset edge
  assign arm[TMR_DUR]    = first_start_i & dur_en_i & ~rst_edge_i;
  assign stop[TMR_DUR]   = ~dur_en_i | rst_edge_i;
  assign tick[TMR_DUR]   = etu_tick_i;
  assign thr[TMR_DUR]    = dur_thr_i;
  assign we[TMR_DUR]     = dur_thr_we_i;
  assign clr[TMR_DUR]    = dur_clr_i;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam logic [CNT_W-1:0] RST_VAL =
      (g == TMR_START) ? CNT_W'(START_RST) : CNT_W'(DUR_RST);

    atr_down_timer #(
      .CNT_W  (CNT_W),
      .RST_THR(RST_VAL)
    ) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (arm[g]),
      .stop_i  (stop[g]),
      .tick_i  (tick[g]),
      .thr_i   (thr[g]),
      .thr_we_i(we[g]),
      .run_o   (run[g]),
      .fire_o  (fire[g])
    );

    atr_irq_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (fire[g]),
      .clr_i (clr[g]),
      .flag_o(irq[g])
    );
  end

  assign start_irq_o = irq[TMR_START];
  assign dur_irq_o   = irq[TMR_DUR];
endmodule

// File: rtl/atr_timeout_monitor_chk.sv
module atr_timeout_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cclk_tick_i,
  input logic       etu_tick_i,
  input logic       first_start_i,
  input logic       rst_edge_i,
  input logic       dur_en_i,
  input logic       start_clr_i,
  input logic       dur_clr_i,
  input logic       start_irq_o,
  input logic       dur_irq_o,
  input logic [1:0] fire
);
  assert_start_unit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[0] |-> cclk_tick_i);
  assert_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_start_i || rst_edge_i) |-> !fire[0]);
  assert_dur_unit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[1] |-> etu_tick_i);
  assert_dur_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dur_en_i |-> !fire[1]);
  assert_start_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[0] |=> start_irq_o);
  assert_dur_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[1] |=> dur_irq_o);
  assert_start_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_irq_o && !start_clr_i) |=> start_irq_o);
  assert_dur_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_irq_o && !dur_clr_i) |=> dur_irq_o);
  assert_start_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_clr_i && !fire[0]) |=> !start_irq_o);
  assert_dur_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_clr_i && !fire[1]) |=> !dur_irq_o);
endmodule

bind atr_timeout_monitor atr_timeout_monitor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cclk_tick_i  (cclk_tick_i),
  .etu_tick_i   (etu_tick_i),
  .first_start_i(first_start_i),
  .rst_edge_i   (rst_edge_i),
  .dur_en_i     (dur_en_i),
  .start_clr_i  (start_clr_i),
  .dur_clr_i    (dur_clr_i),
  .start_irq_o  (start_irq_o),
  .dur_irq_o    (dur_irq_o),
  .fire         (fire)
);

// File: tb/atr_timeout_monitor_tb_top.sv
module atr_timeout_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cclk_tick_i = 1'b0, etu_tick_i = 1'b0;
  logic        rst_edge_i = 1'b0, first_start_i = 1'b0, dur_en_i = 1'b0;
  logic [15:0] start_thr_i = '0, dur_thr_i = '0;
  logic        start_thr_we_i = 1'b0, dur_thr_we_i = 1'b0;
  logic        start_clr_i = 1'b0, dur_clr_i = 1'b0;
  logic        start_irq_o, dur_irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  atr_timeout_monitor dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit e);
    cclk_tick_i = c; etu_tick_i = e;
    @(negedge clk_i);
    cclk_tick_i = 1'b0; etu_tick_i = 1'b0;
  endtask

  task automatic arm_start();
    rst_edge_i = 1'b1; @(negedge clk_i); rst_edge_i = 1'b0;
  endtask

  task automatic first_sb();
    first_start_i = 1'b1; @(negedge clk_i); first_start_i = 1'b0;
  endtask

  task automatic wr_start(input int v);
    start_thr_i = 16'(v); start_thr_we_i = 1'b1;
    @(negedge clk_i); start_thr_we_i = 1'b0;
  endtask

  task automatic wr_dur(input int v);
    dur_thr_i = 16'(v); dur_thr_we_i = 1'b1;
    @(negedge clk_i); dur_thr_we_i = 1'b0;
  endtask

  task automatic clr_both();
    start_clr_i = 1'b1; dur_clr_i = 1'b1;
    @(negedge clk_i);
    start_clr_i = 1'b0; dur_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 start flag", start_irq_o, 0);
    chk("R1 dur flag", dur_irq_o, 0);

    // R1 default start threshold 40000
    arm_start();
    cclk_tick_i = 1'b1;
    for (int i = 1; i <= 40000; i++) begin
      @(negedge clk_i);
      if (i == 39999) chk("R1 start default early", start_irq_o, 0);
      if (i == 40000) chk("R1 start default fire", start_irq_o, 1);
    end
    cclk_tick_i = 1'b0;

    // R1 default duration threshold 19200
    dur_en_i = 1'b1;
    first_sb();
    etu_tick_i = 1'b1;
    for (int i = 1; i <= 19200; i++) begin
      @(negedge clk_i);
      if (i == 19199) chk("R1 dur default early", dur_irq_o, 0);
      if (i == 19200) chk("R1 dur default fire", dur_irq_o, 1);
    end
    etu_tick_i = 1'b0;
    clr_both();

    // R2 sweep of start thresholds, with idle cycles between ticks
    for (int thr = 0; thr <= 6; thr++) begin
      wr_start(thr); clr_both(); arm_start();
      for (int k = 1; k <= 8; k++) begin
        cyc(0, 0);
        cyc(1, 0);
        chk($sformatf("R2 thr=%0d tick=%0d", thr, k), start_irq_o,
            (k >= ((thr < 1) ? 1 : thr)) ? 1 : 0);
      end
    end

    // R4 sweep of duration thresholds; card ticks must not count. R3 abort.
    for (int thr = 0; thr <= 6; thr++) begin
      wr_dur(thr); clr_both(); dur_en_i = 1'b1;
      arm_start(); first_sb();
      for (int k = 1; k <= 8; k++) begin
        cyc(1, 0);
        chk($sformatf("R4 card tick no count thr=%0d k=%0d", thr, k), dur_irq_o,
            (k - 1 >= ((thr < 1) ? 1 : thr)) ? 1 : 0);
        cyc(0, 1);
        chk($sformatf("R4 thr=%0d etu=%0d", thr, k), dur_irq_o,
            (k >= ((thr < 1) ? 1 : thr)) ? 1 : 0);
      end
      chk("R3 start stopped silently", start_irq_o, 0);
    end

    // R6 reload while running: write with tick in the same cycle
    wr_start(10); clr_both(); arm_start();
    for (int k = 0; k < 3; k++) cyc(1, 0);
    start_thr_i = 16'd4; start_thr_we_i = 1'b1; cclk_tick_i = 1'b1;
    @(negedge clk_i);
    start_thr_we_i = 1'b0; cclk_tick_i = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      cyc(1, 0);
      chk($sformatf("R6 start reload tick=%0d", k), start_irq_o, (k == 4) ? 1 : 0);
    end
    wr_dur(10); clr_both(); dur_en_i = 1'b1; first_sb();
    cyc(0, 1); cyc(0, 1);
    dur_thr_i = 16'd2; dur_thr_we_i = 1'b1; etu_tick_i = 1'b1;
    @(negedge clk_i);
    dur_thr_we_i = 1'b0; etu_tick_i = 1'b0;
    cyc(0, 1); chk("R6 dur reload tick 1", dur_irq_o, 0);
    cyc(0, 1); chk("R6 dur reload tick 2", dur_irq_o, 1);

    // R8 one-shot: after clear, more ticks raise nothing
    clr_both();
    for (int k = 0; k < 6; k++) cyc(1, 1);
    chk("R8 start one-shot", start_irq_o, 0);
    chk("R8 dur one-shot", dur_irq_o, 0);

    // R7 idle write only stores
    wr_start(2);
    for (int k = 0; k < 4; k++) cyc(1, 0);
    chk("R7 idle write no flag", start_irq_o, 0);
    arm_start();
    cyc(1, 0); chk("R7 stored value tick 1", start_irq_o, 0);
    cyc(1, 0); chk("R7 stored value tick 2", start_irq_o, 1);

    // R9 expiry coincident with clear: set wins, then hold, then clear
    clr_both(); wr_start(2); arm_start();
    cyc(1, 0);
    start_clr_i = 1'b1; cclk_tick_i = 1'b1;
    @(negedge clk_i);
    start_clr_i = 1'b0; cclk_tick_i = 1'b0;
    chk("R9 set wins over clear", start_irq_o, 1);
    for (int k = 0; k < 3; k++) cyc(0, 0);
    chk("R9 flag held", start_irq_o, 1);
    start_clr_i = 1'b1; @(negedge clk_i); start_clr_i = 1'b0;
    chk("R9 clear", start_irq_o, 0);

    // R5 enable drop disarms; re-enable does not resume
    wr_dur(4); clr_both(); dur_en_i = 1'b1; first_sb();
    cyc(0, 1); cyc(0, 1);
    dur_en_i = 1'b0; @(negedge clk_i); dur_en_i = 1'b1;
    for (int k = 0; k < 10; k++) cyc(0, 1);
    chk("R5 disarmed stays quiet", dur_irq_o, 0);
    dur_en_i = 1'b0; first_sb();
    for (int k = 0; k < 10; k++) cyc(0, 1);
    chk("R5 no arm with enable low", dur_irq_o, 0);
    dur_en_i = 1'b1;

    // R10 restart of start timer
    wr_start(5); clr_both(); arm_start();
    for (int k = 0; k < 3; k++) cyc(1, 0);
    arm_start();
    for (int k = 1; k <= 5; k++) begin
      cyc(1, 0);
      chk($sformatf("R10 restart tick=%0d", k), start_irq_o, (k == 5) ? 1 : 0);
    end
    // R10 reset edge disarms duration timer
    wr_dur(3); clr_both(); first_sb();
    cyc(0, 1);
    arm_start();
    for (int k = 0; k < 5; k++) cyc(0, 1);
    chk("R10 dur disarmed by reset edge", dur_irq_o, 0);
    // R10 simultaneous reset edge and first start bit
    clr_both();
    rst_edge_i = 1'b1; first_start_i = 1'b1;
    @(negedge clk_i);
    rst_edge_i = 1'b0; first_start_i = 1'b0;
    for (int k = 0; k < 5; k++) cyc(0, 1);
    chk("R10 simultaneous: dur not armed", dur_irq_o, 0);
    for (int k = 0; k < 5; k++) cyc(1, 0);
    chk("R10 simultaneous: start armed", start_irq_o, 1);

    finish_run();
  end
endmodule